// File: doc/BRIEF.md
# Quad-Precision Floating-Point Compare Unit

This block compares two IEEE 754 binary128 operands and returns a 4-bit condition code that marks the pair as less-than, greater-than, equal or unordered. It also reports two invalid-operation flags. One flag marks a signaling NaN operand. The other marks an invalid compare. Each operand arrives as two 64-bit halves. The high half carries the sign, the 15-bit exponent and the upper 48 fraction bits.

A one-cycle request strobe starts a compare. A mode input selects ordered or unordered semantics. A trap-enable input gives the current setting of the invalid-operation trap. On the next clock edge the code and both flags are registered, and a done pulse lasts one cycle. The code drives a single port. The surrounding core copies that port into both its floating-point status result field and the chosen condition-register field, so the two fields always hold the same value. The outputs keep their values until the next request.

Top module: `qp_compare_unit`

## Requirements
- R1: Code bits are LT=4'b1000, GT=4'b0100, EQ=4'b0010, UN=4'b0001. Code and flags load on the clock edge that samples `req_valid`=1. `done` is 1 for exactly the cycle after that edge.
- R2: The high half `*_hi` is the most significant doubleword: sign at bit 63, exponent at bits 62:48, fraction MSB at bit 47. The low half holds fraction bits 63:0.
- R3: An operand with an all-ones exponent, a non-zero fraction and fraction MSB 0 is a signaling NaN. If either operand is one, the code is UN only and `flag_snan` is 1.
- R4: In ordered mode (`ordered_mode`=1), a signaling NaN also sets `flag_invcmp`, but only when `inv_trap_en` is 0. In unordered mode a signaling NaN never sets `flag_invcmp`.
- R5: An operand with an all-ones exponent and fraction MSB 1 is a quiet NaN. If there is a quiet NaN and no signaling NaN, the code is UN only and `flag_snan` is 0. `flag_invcmp` is 1 in ordered mode and 0 in unordered mode.
- R6: When neither operand is a NaN, exactly one of LT, GT or EQ is set, and UN is 0. LT means a<b, EQ means a==b, and GT covers every other case.
- R7: +0 and -0 compare equal, whatever their signs.
- R8: When both operands are negative, the larger magnitude is the smaller value. Infinities are ordered by sign like finite values.
- R9: Every compare first clears both flags. A non-NaN compare that follows a flagged compare reports both flags as 0.
- R10: Reset clears the code to 4'b0000 and clears `done` and both flags.
- R11: When `req_valid` is 0, the code and flags hold their values and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Starts a compare of the current operands |
| ordered_mode | input | 1 | 1 = ordered semantics, 0 = unordered |
| inv_trap_en | input | 1 | Current invalid-operation trap enable |
| opa_hi | input | 64 | Operand A, most significant doubleword |
| opa_lo | input | 64 | Operand A, least significant doubleword |
| opb_hi | input | 64 | Operand B, most significant doubleword |
| opb_lo | input | 64 | Operand B, least significant doubleword |
| done | output | 1 | One-cycle pulse marking a new result |
| cmp_code | output | 4 | Condition code for the status and CR fields |
| flag_snan | output | 1 | Signaling-NaN invalid-operation flag |
| flag_invcmp | output | 1 | Invalid-compare flag |

## Verification
The checker assumes that `req_valid` is a known level after reset. It also assumes that the operands, `ordered_mode` and `inv_trap_en` are valid in every cycle where `req_valid` is 1. Outside those cycles the design ignores them. The bench drives every input on the falling edge and holds each request for exactly one clock, so every value is settled before the sampling edge. The bench runs compares back to back and also with idle gaps between them. This exercises the property that done follows the strobe by one cycle, and the property that the code holds when no request arrives.

// File: rtl/qp_cmp_pkg.sv
package qp_cmp_pkg;
  localparam int CC_W = 4;
  localparam logic [CC_W-1:0] CC_LT = 4'b1000;
  localparam logic [CC_W-1:0] CC_GT = 4'b0100;
  localparam logic [CC_W-1:0] CC_EQ = 4'b0010;
  localparam logic [CC_W-1:0] CC_UN = 4'b0001;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_qnan;
    logic is_zero;
  } qp_class_t;
endpackage

// File: rtl/qp_classify.sv
module qp_classify
  import qp_cmp_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 112
) (
  input  logic [EXP_W-1:0]  expo,
  input  logic [FRAC_W-1:0] frac,
  output qp_class_t         cls
);
  logic exp_ones;
  logic exp_zero;
  logic frac_zero;

  always_comb begin
    exp_ones    = &expo;
    exp_zero    = ~|expo;
    frac_zero   = ~|frac;
    cls.is_nan  = exp_ones & ~frac_zero;
    cls.is_qnan = exp_ones & frac[FRAC_W-1];
    cls.is_snan = exp_ones & ~frac[FRAC_W-1] & ~frac_zero;
    cls.is_zero = exp_zero & frac_zero;
  end
endmodule

// File: rtl/qp_order.sv
module qp_order #(
  parameter int W = 128
) (
  input  logic [W-1:0] val_a,
  input  logic [W-1:0] val_b,
  input  logic         zero_a,
  input  logic         zero_b,
  output logic         a_lt_b,
  output logic         a_eq_b
);
  localparam int MAG_W = W - 1;

  logic             sgn_a;
  logic             sgn_b;
  logic [MAG_W-1:0] mag_a;
  logic [MAG_W-1:0] mag_b;
  logic             mag_lt;
  logic             mag_eq;

  always_comb begin
    sgn_a  = val_a[W-1];
    sgn_b  = val_b[W-1];
    mag_a  = val_a[MAG_W-1:0];
    mag_b  = val_b[MAG_W-1:0];
    mag_lt = mag_a < mag_b;
    mag_eq = mag_a == mag_b;

    if (zero_a && zero_b) begin
      a_lt_b = 1'b0;
      a_eq_b = 1'b1;
    end else if (sgn_a != sgn_b) begin
      a_lt_b = sgn_a;
      a_eq_b = 1'b0;
    end else if (!sgn_a) begin
      a_lt_b = mag_lt;
      a_eq_b = mag_eq;
    end else begin
      a_lt_b = ~mag_lt & ~mag_eq;
      a_eq_b = mag_eq;
    end
  end
endmodule

// File: rtl/qp_cc_next.sv
module qp_cc_next
  import qp_cmp_pkg::*;
(
  input  qp_class_t       cls_a,
  input  qp_class_t       cls_b,
  input  logic            a_lt_b,
  input  logic            a_eq_b,
  input  logic            ordered_mode,
  input  logic            inv_trap_en,
  output logic [CC_W-1:0] cc_nxt,
  output logic            snan_nxt,
  output logic            invcmp_nxt
);
  logic any_snan;
  logic any_qnan;

  always_comb begin
    any_snan   = cls_a.is_snan | cls_b.is_snan;
    any_qnan   = cls_a.is_qnan | cls_b.is_qnan;
    snan_nxt   = 1'b0;
    invcmp_nxt = 1'b0;
    if (any_snan) begin
      cc_nxt     = CC_UN;
      snan_nxt   = 1'b1;
      invcmp_nxt = ordered_mode & ~inv_trap_en;
    end else if (any_qnan || cls_a.is_nan || cls_b.is_nan) begin
      cc_nxt     = CC_UN;
      invcmp_nxt = ordered_mode;
    end else if (a_lt_b) begin
      cc_nxt = CC_LT;
    end else if (a_eq_b) begin
      cc_nxt = CC_EQ;
    end else begin
      cc_nxt = CC_GT;
    end
  end
endmodule

// File: rtl/qp_compare_unit.sv
module qp_compare_unit
  import qp_cmp_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int EXP_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              ordered_mode,
  input  logic              inv_trap_en,
  input  logic [HALF_W-1:0] opa_hi,
  input  logic [HALF_W-1:0] opa_lo,
  input  logic [HALF_W-1:0] opb_hi,
  input  logic [HALF_W-1:0] opb_lo,
  output logic              done,
  output logic [CC_W-1:0]   cmp_code,
  output logic              flag_snan,
  output logic              flag_invcmp
);
  localparam int QW     = 2 * HALF_W;
  localparam int FRAC_W = QW - 1 - EXP_W;
  localparam int N_OPS  = 2;

  logic [QW-1:0]   op_word [N_OPS];
  qp_class_t       op_cls  [N_OPS];
  logic            a_lt_b;
  logic            a_eq_b;
  logic [CC_W-1:0] cc_nxt;
  logic            snan_nxt;
  logic            invcmp_nxt;

  always_comb begin
    op_word[0] = {opa_hi, opa_lo};
    op_word[1] = {opb_hi, opb_lo};
  end

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    qp_classify #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W)
    ) i_qp_classify (
      .expo(op_word[g][QW-2 -: EXP_W]),
      .frac(op_word[g][FRAC_W-1:0]),
      .cls (op_cls[g])
    );
  end

  qp_order #(
    .W(QW)
  ) i_qp_order (
    .val_a (op_word[0]),
    .val_b (op_word[1]),
    .zero_a(op_cls[0].is_zero),
    .zero_b(op_cls[1].is_zero),
    .a_lt_b(a_lt_b),
    .a_eq_b(a_eq_b)
  );

  qp_cc_next i_qp_cc_next (
    .cls_a       (op_cls[0]),
    .cls_b       (op_cls[1]),
    .a_lt_b      (a_lt_b),
    .a_eq_b      (a_eq_b),
    .ordered_mode(ordered_mode),
    .inv_trap_en (inv_trap_en),
    .cc_nxt      (cc_nxt),
    .snan_nxt    (snan_nxt),
    .invcmp_nxt  (invcmp_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else begin
      done <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_code    <= '0;
      flag_snan   <= 1'b0;
      flag_invcmp <= 1'b0;
    end else if (req_valid) begin
      cmp_code    <= cc_nxt;
      flag_snan   <= snan_nxt;
      flag_invcmp <= invcmp_nxt;
    end
  end
endmodule

// File: rtl/qp_compare_unit_chk.sv
module qp_compare_unit_chk
  import qp_cmp_pkg::*;
#(
  parameter int HALF_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              ordered_mode,
  input logic              inv_trap_en,
  input logic [HALF_W-1:0] opa_hi,
  input logic [HALF_W-1:0] opa_lo,
  input logic [HALF_W-1:0] opb_hi,
  input logic [HALF_W-1:0] opb_lo,
  input logic              done,
  input logic [CC_W-1:0]   cmp_code,
  input logic              flag_snan,
  input logic              flag_invcmp
);
  AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmp_code)); // R1
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done); // R1
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(cmp_code) && $stable(flag_snan) && $stable(flag_invcmp))); // R11
  AST_SNAN_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_snan |-> cmp_code == CC_UN); // R3
  AST_INVCMP_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invcmp |-> cmp_code == CC_UN); // R5
  AST_UNORD_MODE_NO_INVCMP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ordered_mode) |=> !flag_invcmp); // R4
  AST_TRAP_SNAN_NO_INVCMP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && inv_trap_en) |=> !(flag_invcmp && flag_snan)); // R4
endmodule

bind qp_compare_unit qp_compare_unit_chk #(.HALF_W(HALF_W)) i_qp_compare_unit_chk (.*);

// File: tb/test_qp_compare_unit.sv
module test_qp_compare_unit;
  localparam logic [63:0] P1   = 64'h3FFF_0000_0000_0000;
  localparam logic [63:0] P2   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] N1   = 64'hBFFF_0000_0000_0000;
  localparam logic [63:0] N2   = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FFF_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFFF_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7FFF_8000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [3:0]  LT = 4'b1000, GT = 4'b0100, EQ = 4'b0010, UN = 4'b0001;

  typedef struct {
    logic [3:0] cc;
    logic       sn;
    logic       ic;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        ordered_mode = 1'b0;
  logic        inv_trap_en = 1'b0;
  logic [63:0] opa_hi = '0, opa_lo = '0, opb_hi = '0, opb_lo = '0;
  logic        done;
  logic [3:0]  cmp_code;
  logic        flag_snan;
  logic        flag_invcmp;

  int   n_chk = 0;
  int   n_fail = 0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  qp_compare_unit i_qp_compare_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .ordered_mode(ordered_mode), .inv_trap_en(inv_trap_en),
    .opa_hi(opa_hi), .opa_lo(opa_lo), .opb_hi(opb_hi), .opb_lo(opb_lo),
    .done(done), .cmp_code(cmp_code), .flag_snan(flag_snan), .flag_invcmp(flag_invcmp)
  );

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp_v);
    end
  endtask

  task automatic issue(input logic [63:0] ah, input logic [63:0] al,
                       input logic [63:0] bh, input logic [63:0] bl,
                       input logic ord, input logic te,
                       input logic [3:0] cc, input logic sn, input logic ic,
                       input string tag);
    exp_t e;
    @(negedge clk);
    opa_hi = ah; opa_lo = al; opb_hi = bh; opb_lo = bl;
    ordered_mode = ord; inv_trap_en = te; req_valid = 1'b1;
    e.cc = cc; e.sn = sn; e.ic = ic; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor: each done pulse pops one expected result
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check("R1 unexpected done", 6'b1, 6'b0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, {cmp_code, flag_snan, flag_invcmp}, {e.cc, e.sn, e.ic});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset state", {done, cmp_code, flag_snan}, 6'b0);
    check("R10 reset invcmp", {5'b0, flag_invcmp}, 6'b0);
    rst_n = 1'b1;
    idle(2);

    // R6 R1: ordinary ordering, back to back
    issue(P1, '0, P2, '0, 1'b1, 1'b0, LT, 1'b0, 1'b0, "R6 1<2");
    issue(P2, '0, P1, '0, 1'b1, 1'b0, GT, 1'b0, 1'b0, "R6 2>1");
    issue(P1, '0, P1, '0, 1'b0, 1'b0, EQ, 1'b0, 1'b0, "R6 1==1");
    issue(N1, '0, P1, '0, 1'b0, 1'b0, LT, 1'b0, 1'b0, "R6 -1<1");
    // R2: the low half is least significant
    issue(P1, 64'h1, P1, '0, 1'b0, 1'b0, GT, 1'b0, 1'b0, "R2 low half lsb");
    issue(PZ, P1, P1, '0, 1'b0, 1'b0, LT, 1'b0, 1'b0, "R2 high half msb");
    // R7
    issue(PZ, '0, NZ, '0, 1'b1, 1'b0, EQ, 1'b0, 1'b0, "R7 +0==-0");
    issue(NZ, '0, PZ, '0, 1'b0, 1'b0, EQ, 1'b0, 1'b0, "R7 -0==+0");
    // R8
    issue(N2, '0, N1, '0, 1'b1, 1'b0, LT, 1'b0, 1'b0, "R8 -2<-1");
    issue(N1, '0, N2, '0, 1'b1, 1'b0, GT, 1'b0, 1'b0, "R8 -1>-2");
    issue(NINF, '0, N2, '0, 1'b0, 1'b0, LT, 1'b0, 1'b0, "R8 -inf<-2");
    issue(PINF, '0, P2, '0, 1'b0, 1'b0, GT, 1'b0, 1'b0, "R8 +inf>2");
    issue(PINF, '0, PINF, '0, 1'b0, 1'b0, EQ, 1'b0, 1'b0, "R8 inf==inf");
    // R3 R4: signaling NaN
    issue(PINF, 64'h1, P1, '0, 1'b1, 1'b0, UN, 1'b1, 1'b1, "R4 snan ordered trap off");
    issue(P1, '0, PINF, 64'h1, 1'b1, 1'b1, UN, 1'b1, 1'b0, "R4 snan ordered trap on");
    issue(PINF, 64'h1, PINF, 64'h1, 1'b0, 1'b0, UN, 1'b1, 1'b0, "R3 snan unordered");
    issue(QNAN, '0, PINF, 64'h1, 1'b0, 1'b1, UN, 1'b1, 1'b0, "R3 snan with qnan");
    // R9: flags cleared by next clean compare
    issue(P2, '0, P2, '0, 1'b1, 1'b0, EQ, 1'b0, 1'b0, "R9 flags cleared");
    // R5: quiet NaN
    issue(QNAN, '0, P1, '0, 1'b1, 1'b1, UN, 1'b0, 1'b1, "R5 qnan ordered");
    issue(P1, '0, QNAN, '0, 1'b0, 1'b0, UN, 1'b0, 1'b0, "R5 qnan unordered");
    issue(QNAN, '0, QNAN, '0, 1'b1, 1'b0, UN, 1'b0, 1'b1, "R5 both qnan ordered");
    issue(QNAN, '0, P1, '0, 1'b1, 1'b0, UN, 1'b0, 1'b1, "R9 before idle");
    idle(1);

    // R11: idle with changing inputs holds outputs and no done
    opa_hi = P2; opb_hi = P1; ordered_mode = 1'b0;
    idle(3);
    check("R11 idle hold", {done, cmp_code, flag_snan}, {1'b0, UN, 1'b0});
    check("R11 idle hold invcmp", {5'b0, flag_invcmp}, 6'b1);
    issue(P2, '0, P1, '0, 1'b0, 1'b0, GT, 1'b0, 1'b0, "R9 clean after idle");
    idle(3);
    check("R1 all results seen", sb_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule